// File: doc/BRIEF.md
# Serial Multi-Layer Perceptron Classifier

This block is a feed-forward neural classifier that runs fully in sequence. It takes 220 signed input values, passes them through 24 hidden neurons, and scores 10 output classes. A single weight store, a single multiply-accumulate unit and a single activation unit serve every neuron in both layers, one product per clock. The engine trades speed for area: it never computes two products at the same time.

Before a run, the host fills the weight store through a write port and loads the input vector into an input buffer. It then pulses `start`. The engine works through each hidden neuron in turn and writes every activated result into a hidden buffer. The output layer then reuses the same datapath, and its inputs are the hidden-buffer values re-centred around zero. When the last class score has been written, `done` rises. All ten 8-bit scores stay readable in parallel on `scores`.

Top module: `mlp_serial_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and every score reads 0.
- R2: Each term is the signed 8-bit operand times the signed 8-bit weight, a 16-bit product. The product is sign-extended to 23 bits and added to an accumulator. The accumulator is cleared before the first term of every neuron.
- R3: The activation maps a 23-bit sum s to 8 bits as follows. First compute d = floor(s/64). When |d| <= 64 the result is 128+d. When d > 64 the result is 192+floor((d-64)/4), saturating at 255. When d < -64 the result is 64-floor((-d-64)/4), saturating at 0.
- R4: Hidden neuron n (0..23) sums input i (0..219) times the weight at address {1'b0, n[4:0], i[7:0]}. The input vector is written through `x_addr`/`x_data`.
- R5: Output class c (0..9) sums, over j = 0..23, (hidden[j] - 128) times the weight at address {1'b1, c[4:0], j[7:0]}.
- R6: `done` rises exactly 5554 clock edges after the edge that samples `start`. This figure is 24×221 + 10×25.
- R7: A `start` that arrives while `busy` is high has no effect, including in the final cycle of a run.
- R8: `done` stays high until the next accepted `start`. A `start` accepted while `done` is high begins a new run, and `done` is low after that edge.
- R9: The score of class c is unsigned and sits on `scores[8c+7:8c]`. Scores hold their value while the engine is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| w_we | input | 1 | Weight write enable |
| w_addr | input | 14 | Weight address {layer, neuron[4:0], term[7:0]} |
| w_data | input | 8 | Signed weight |
| x_we | input | 1 | Input-buffer write enable |
| x_addr | input | 8 | Input index 0..219 |
| x_data | input | 8 | Signed input value |
| start | input | 1 | Begin a run when idle or done |
| busy | output | 1 | Run in progress |
| done | output | 1 | Scores valid |
| scores | output | 80 | Ten unsigned 8-bit class scores |

## Verification
Two events can fall in the same cycle: the final output activation, which ends the run, and an incoming `start`. The bench provokes this by counting edges from an accepted start and raising `start` so that it is sampled exactly on edge 5554. A correct engine ignores that pulse. It must show `done` high and `busy` low for several cycles afterwards, with unchanged scores. Mid-run start pulses are checked the same way, by timing the latency and comparing every score against values the bench computes itself.

// File: rtl/mlp_pkg.sv
package mlp_pkg;
  localparam int DATA_W    = 8;
  localparam int PROD_W    = 2 * DATA_W;
  localparam int ACC_W     = 23;
  localparam int ACT_SHIFT = 6;
  localparam int KNEE      = 64;
  localparam int MID       = 128;
  localparam int TOP_VAL   = 255;

  typedef enum logic [2:0] {
    S_IDLE, S_HACC, S_HACT, S_OACC, S_OACT, S_DONE
  } eng_state_t;

  typedef logic signed [DATA_W-1:0] sdata_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // signed product widened to the accumulator width
  function automatic acc_t ext_product(sdata_t a, sdata_t b);
    logic signed [PROD_W-1:0] p;
    p = a * b;
    return ACC_W'(p);
  endfunction

  // piecewise saturating sigmoid approximation
  function automatic logic [DATA_W-1:0] sigmoid_pw(acc_t s);
    int d;
    int t;
    d = int'(s >>> ACT_SHIFT);
    if (d > KNEE)       t = 3 * KNEE + ((d - KNEE) >>> 2);
    else if (d < -KNEE) t = KNEE - ((-d - KNEE) >>> 2);
    else                t = MID + d;
    if (t > TOP_VAL) t = TOP_VAL;
    if (t < 0)       t = 0;
    return DATA_W'(t);
  endfunction
endpackage

// File: rtl/mlp_weight_mem.sv
module mlp_weight_mem
  import mlp_pkg::*;
#(
  parameter int N_IN  = 220,
  parameter int N_HID = 24,
  parameter int N_OUT = 10,
  parameter int IW    = 8,
  parameter int NW    = 5,
  localparam int AW   = 1 + NW + IW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  sdata_t        wr_data,
  input  logic [AW-1:0] rd_addr,
  output sdata_t        rd_data
);
  localparam int HID_WORDS = N_HID * N_IN;
  localparam int OUT_WORDS = N_OUT * N_HID;
  localparam int DEPTH     = HID_WORDS + OUT_WORDS;
  localparam int MW        = $clog2(DEPTH);

  sdata_t mem [DEPTH];

  // fold the {layer, neuron, term} address onto dense storage
  function automatic int fold(logic [AW-1:0] a);
    int n;
    int i;
    n = int'(a[IW +: NW]);
    i = int'(a[IW-1:0]);
    if (a[AW-1]) return HID_WORDS + n * N_HID + i;
    return n * N_IN + i;
  endfunction

  function automatic logic in_range(logic [AW-1:0] a);
    int n;
    int i;
    n = int'(a[IW +: NW]);
    i = int'(a[IW-1:0]);
    if (a[AW-1]) return (n < N_OUT) && (i < N_HID);
    return (n < N_HID) && (i < N_IN);
  endfunction

  logic wr_ok;
  assign wr_ok = wr_en && in_range(wr_addr);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[MW'(fold(wr_addr))] <= wr_data;
  end

  assign rd_data = mem[MW'(fold(rd_addr))];
endmodule

// File: rtl/mlp_mac.sv
module mlp_mac
  import mlp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   en,
  input  sdata_t opa,
  input  sdata_t opb,
  output acc_t   acc
);
  acc_t term;
  assign term = ext_product(opa, opb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + term;
  end

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
endmodule

// File: rtl/mlp_activation.sv
module mlp_activation
  import mlp_pkg::*;
(
  input  acc_t              sum,
  output logic [DATA_W-1:0] y
);
  assign y = sigmoid_pw(sum);

  // R3
  always_comb begin
    act_sign_chk: assert ((sum >= 0) ? (y >= 8'(MID)) : (y <= 8'(MID)));
  end
endmodule

// File: rtl/mlp_ctrl.sv
module mlp_ctrl
  import mlp_pkg::*;
#(
  parameter int N_IN  = 220,
  parameter int N_HID = 24,
  parameter int N_OUT = 10,
  parameter int IW    = 8,
  parameter int NW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output eng_state_t    state,
  output logic [IW-1:0] term_idx,
  output logic [NW-1:0] neu_idx,
  output logic          out_layer,
  output logic          acc_en,
  output logic          acc_clr,
  output logic          hid_we,
  output logic          score_we,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST_IN  = IW'(N_IN - 1);
  localparam logic [IW-1:0] LAST_HT  = IW'(N_HID - 1);
  localparam logic [NW-1:0] LAST_HN  = NW'(N_HID - 1);
  localparam logic [NW-1:0] LAST_ON  = NW'(N_OUT - 1);

  logic accept_evt;
  logic hid_last_term_evt;
  logic out_last_term_evt;
  logic hid_layer_end_evt;
  logic run_end_evt;

  assign busy  = (state != S_IDLE) && (state != S_DONE);
  assign done  = (state == S_DONE);
  assign accept_evt        = start && !busy;
  assign hid_last_term_evt = (state == S_HACC) && (term_idx == LAST_IN);
  assign out_last_term_evt = (state == S_OACC) && (term_idx == LAST_HT);
  assign hid_layer_end_evt = (state == S_HACT) && (neu_idx == LAST_HN);
  assign run_end_evt       = (state == S_OACT) && (neu_idx == LAST_ON);

  assign out_layer = (state == S_OACC) || (state == S_OACT);
  assign acc_en    = (state == S_HACC) || (state == S_OACC);
  assign acc_clr   = accept_evt || (state == S_HACT) || (state == S_OACT);
  assign hid_we    = (state == S_HACT);
  assign score_we  = (state == S_OACT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      term_idx <= '0;
      neu_idx  <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: begin
          if (accept_evt) begin
            state    <= S_HACC;
            term_idx <= '0;
            neu_idx  <= '0;
          end
        end
        S_HACC: begin
          if (hid_last_term_evt) state <= S_HACT;
          else                   term_idx <= term_idx + 1'b1;
        end
        S_HACT: begin
          term_idx <= '0;
          if (hid_layer_end_evt) begin
            neu_idx <= '0;
            state   <= S_OACC;
          end else begin
            neu_idx <= neu_idx + 1'b1;
            state   <= S_HACC;
          end
        end
        S_OACC: begin
          if (out_last_term_evt) state <= S_OACT;
          else                   term_idx <= term_idx + 1'b1;
        end
        S_OACT: begin
          term_idx <= '0;
          if (run_end_evt) begin
            neu_idx <= '0;
            state   <= S_DONE;
          end else begin
            neu_idx <= neu_idx + 1'b1;
            state   <= S_OACC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HACC && !hid_last_term_evt) |=> (state == S_HACC));

  // R7
  last_step_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_end_evt |=> (state == S_DONE));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (state == S_HACC && term_idx == '0 && neu_idx == '0));

  // R4
  term_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HACC) |-> (int'(term_idx) < N_IN && int'(neu_idx) < N_HID));

  // R5
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OACC) |-> (int'(term_idx) < N_HID && int'(neu_idx) < N_OUT));
endmodule

// File: rtl/mlp_serial_engine.sv
module mlp_serial_engine
  import mlp_pkg::*;
#(
  parameter int N_IN  = 220,
  parameter int N_HID = 24,
  parameter int N_OUT = 10,
  localparam int IW   = $clog2(N_IN),
  localparam int NW   = ($clog2(N_HID) > $clog2(N_OUT)) ? $clog2(N_HID) : $clog2(N_OUT),
  localparam int AW   = 1 + NW + IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                w_we,
  input  logic [AW-1:0]       w_addr,
  input  logic [7:0]          w_data,
  input  logic                x_we,
  input  logic [IW-1:0]       x_addr,
  input  logic [7:0]          x_data,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic [N_OUT*8-1:0]  scores
);
  localparam int HW = $clog2(N_HID);
  localparam int OW = $clog2(N_OUT);

  eng_state_t        state;
  logic [IW-1:0]     term_idx;
  logic [NW-1:0]     neu_idx;
  logic              out_layer, acc_en, acc_clr, hid_we, score_we;
  sdata_t            wt, operand;
  acc_t              acc;
  logic [DATA_W-1:0] act_y;
  logic              x_wr_ok;

  sdata_t            in_buf  [N_IN];
  logic [7:0]        hid_buf [N_HID];
  logic [7:0]        score_q [N_OUT];

  mlp_ctrl #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .IW(IW), .NW(NW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state),
    .term_idx(term_idx), .neu_idx(neu_idx), .out_layer(out_layer),
    .acc_en(acc_en), .acc_clr(acc_clr), .hid_we(hid_we), .score_we(score_we),
    .busy(busy), .done(done)
  );

  mlp_weight_mem #(.N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT), .IW(IW), .NW(NW)) u_wmem (
    .clk(clk), .wr_en(w_we), .wr_addr(w_addr), .wr_data(sdata_t'(w_data)),
    .rd_addr({out_layer, neu_idx, term_idx}), .rd_data(wt)
  );

  // hidden values are recentred around zero before reuse
  assign operand = out_layer ? sdata_t'(hid_buf[term_idx[HW-1:0]] ^ 8'h80)
                             : in_buf[term_idx];

  mlp_mac u_mac (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .en(acc_en),
    .opa(operand), .opb(wt), .acc(acc)
  );

  mlp_activation u_act (.sum(acc), .y(act_y));

  assign x_wr_ok = x_we && ({1'b0, x_addr} < (IW+1)'(N_IN));

  always_ff @(posedge clk) begin
    if (x_wr_ok) in_buf[x_addr] <= sdata_t'(x_data);
  end

  always_ff @(posedge clk) begin
    if (hid_we) hid_buf[neu_idx[HW-1:0]] <= act_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_OUT; k++) score_q[k] <= '0;
    end else if (score_we) begin
      score_q[neu_idx[OW-1:0]] <= act_y;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_score
    assign scores[g*8 +: 8] = score_q[g];
  end

  // R9
  scores_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(scores));

  // R1
  idle_scores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (scores == '0));
endmodule

// File: tb/mlp_serial_engine_tb.sv
module mlp_serial_engine_tb;
  localparam int NI = 220;
  localparam int NH = 24;
  localparam int NO = 10;
  localparam int LAT = NH * (NI + 1) + NO * (NH + 1);

  logic clk = 0;
  logic rst_n = 0;
  logic w_we = 0;
  logic [13:0] w_addr = '0;
  logic [7:0] w_data = '0;
  logic x_we = 0;
  logic [7:0] x_addr = '0;
  logic [7:0] x_data = '0;
  logic start = 0;
  logic busy, done;
  logic [NO*8-1:0] scores;

  int checks = 0;
  int fails = 0;
  int xin [NI];
  int hid_ref [NH];
  int exp_sc [NO];

  always #5 clk = ~clk;

  mlp_serial_engine u_dut (
    .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_addr(w_addr), .w_data(w_data),
    .x_we(x_we), .x_addr(x_addr), .x_data(x_data), .start(start),
    .busy(busy), .done(done), .scores(scores)
  );

  function automatic int whid(int n, int i);
    return ((n * 7 + i * 3) % 9) - 4;
  endfunction

  function automatic int wout(int c, int j);
    return ((c * 29 + j * 17) % 101) - 50;
  endfunction

  function automatic int act_ref(int s);
    int d;
    int t;
    d = (s >= 0) ? s / 64 : -((-s + 63) / 64);
    if (d > 64)       t = 192 + (d - 64) / 4;
    else if (d < -64) t = 64 - (-d - 64) / 4;
    else              t = 128 + d;
    if (t > 255) t = 255;
    if (t < 0)   t = 0;
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compute_expected();
    for (int n = 0; n < NH; n++) begin
      int s = 0;
      for (int i = 0; i < NI; i++) s += xin[i] * whid(n, i);
      hid_ref[n] = act_ref(s);
    end
    for (int c = 0; c < NO; c++) begin
      int s = 0;
      for (int j = 0; j < NH; j++) s += (hid_ref[j] - 128) * wout(c, j);
      exp_sc[c] = act_ref(s);
    end
  endtask

  task automatic load_inputs(int pat);
    for (int i = 0; i < NI; i++) begin
      case (pat)
        0: xin[i] = ((i * 13 + 5) % 41) - 20;
        1: xin[i] = ((i * 3) % 9 > 4) ? 127 : -128;
        default: xin[i] = ((i * 31 + 7) % 255) - 127;
      endcase
      @(negedge clk);
      x_we = 1; x_addr = 8'(i); x_data = 8'(xin[i]);
    end
    @(negedge clk);
    x_we = 0;
    compute_expected();
  endtask

  task automatic check_scores(string tag);
    for (int c = 0; c < NO; c++)
      check({tag, " R2 R3 R4 R5 R9 score"}, int'(scores[c*8 +: 8]), exp_sc[c]);
  endtask

  // runs one inference; extra start pulses at given cycle offsets (0 = none)
  task automatic run(int p1, int p2, int p3, output int lat);
    int cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && cnt < 20000) begin
      start = ((cnt + 1 == p1) || (cnt + 1 == p2) || (cnt + 1 == p3));
      @(negedge clk);
      cnt++;
    end
    start = 0;
    lat = cnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 scores", int'(scores != '0), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 scores after release", int'(scores != '0), 0);

    for (int n = 0; n < NH; n++)
      for (int i = 0; i < NI; i++) begin
        @(negedge clk);
        w_we = 1; w_addr = {1'b0, 5'(n), 8'(i)}; w_data = 8'(whid(n, i));
      end
    for (int c = 0; c < NO; c++)
      for (int j = 0; j < NH; j++) begin
        @(negedge clk);
        w_we = 1; w_addr = {1'b1, 5'(c), 8'(j)}; w_data = 8'(wout(c, j));
      end
    @(negedge clk);
    w_we = 0;

    // pattern 0: plain run
    load_inputs(0);
    run(0, 0, 0, lat);
    check("R6 latency", lat, LAT);
    check_scores("pat0");

    // R8: done holds without start
    repeat (20) @(negedge clk);
    check("R8 done hold", int'(done), 1);
    check_scores("pat0 hold");

    // pattern 1: saturating inputs, start pulsed while busy
    load_inputs(1);
    run(100, 3000, 5400, lat);
    check("R7 latency with busy starts", lat, LAT);
    check_scores("pat1");

    // pattern 2: start lands on the final activation step
    load_inputs(2);
    run(LAT, 0, 0, lat);
    check("R6 latency", lat, LAT);
    repeat (5) @(negedge clk);
    check("R7 final-step start done", int'(done), 1);
    check("R7 final-step start busy", int'(busy), 0);
    check_scores("pat2");

    // R8: restart from done
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R8 done drops on restart", int'(done), 0);
    check("R8 busy on restart", int'(busy), 1);
    run(0, 0, 0, lat);
    check_scores("pat2 rerun");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule